// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary counter driven by two separate count strobes, one that steps the value up and one that steps it down. A step is taken on the rising edge of one strobe only while the other strobe is held high. An active-high clear forces the value to zero, and an active-low load copies a parallel data word into the counter. Clear has priority over load.

Two active-low terminal outputs make long counters easy to build. The overflow output pulses low while the value sits at its maximum and the up strobe is low. The underflow output pulses low while the value sits at zero and the down strobe is low. Wiring these two outputs straight into the up and down strobes of a second counter gives a wider up/down count with no glue logic. Both strobes are treated as ordinary data inputs to a single system clock. Each passes through a synchroniser chain, and its edges are found by comparing two successive synchronised samples.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `clr` is high, the count becomes zero on the next system clock edge. This happens whatever the levels on `load_n`, `din`, `up_clk` and `dn_clk`. System reset `rst` also zeroes the count.
- R2: While `clr` is low and `load_n` is low, the count takes the value on `din` on every system clock edge.
- R3: A rising edge on `up_clk` adds one to the count when `dn_clk` is high both before and at that edge.
- R4: A rising edge on `dn_clk` subtracts one from the count when `up_clk` is high both before and at that edge.
- R5: `carry_n` is low exactly when the count equals its maximum (all ones) and the synchronised `up_clk` is low. Otherwise it is high.
- R6: `borrow_n` is low exactly when the count is zero and the synchronised `dn_clk` is low. Otherwise it is high.
- R7: Counting up from the maximum gives zero. Counting down from zero gives the maximum.
- R8: Strobe edges that arrive while `clr` is high or `load_n` is low are dropped. After release, the first qualifying rising edge counts normally.
- R9: When both strobes rise in the same synchronised cycle, the count does not change.
- R10: When `carry_n` and `borrow_n` of one stage drive `up_clk` and `dn_clk` of a second stage, the pair counts as one binary up/down counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel load value |
| up_clk | input | 1 | Count-up strobe, asynchronous |
| dn_clk | input | 1 | Count-down strobe, asynchronous |
| count | output | WIDTH | Registered count value |
| carry_n | output | 1 | Active-low overflow pulse for cascading |
| borrow_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
The bench builds two stages, both with the default WIDTH of 4 and a two-flop synchroniser. With a 4-bit stage, both wrap points and both terminal pulses are reached within a few strobe pulses. Chaining the second stage onto the first stage's terminal outputs makes the 8-bit carry and borrow across the nibble boundary observable. Using the shortest synchroniser keeps each strobe phase to a few system cycles while still exercising the edge-detect path.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/updn_level_sync.sv
module updn_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic prev
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain[0] <= raw;
  end

  genvar gi;
  generate
    for (gi = 1; gi < CHAIN; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= 1'b1;
        else     chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  assign lvl  = chain[STAGES-1];
  assign prev = chain[STAGES];
endmodule

// File: rtl/updn_step_decode.sv
module updn_step_decode
  import updn_pkg::*;
(
  input  logic  up_lvl,
  input  logic  up_prev,
  input  logic  dn_lvl,
  input  logic  dn_prev,
  output step_e step
);
  logic up_rise, dn_rise, up_ok, dn_ok;

  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;
  assign up_ok   = up_rise & dn_lvl & dn_prev;
  assign dn_ok   = dn_rise & up_lvl & up_prev;

  always_comb begin
    if (up_ok)      step = STEP_INC;
    else if (dn_ok) step = STEP_DEC;
    else            step = STEP_HOLD;
  end
endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  step_e            step,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
    end else if (!load_n) begin
      value <= din;
    end else begin
      case (step)
        STEP_INC: value <= value + ONE;
        STEP_DEC: value <= value - ONE;
        default:  value <= value;
      endcase
    end
  end
endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n  = ~((value == TOP) & ~up_lvl);
  assign borrow_n = ~((value == '0)  & ~dn_lvl);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_clk,
  input  logic             dn_clk,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic  up_lvl, up_prev, dn_lvl, dn_prev;
  step_e step;

  updn_level_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .raw(up_clk), .lvl(up_lvl), .prev(up_prev)
  );

  updn_level_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .raw(dn_clk), .lvl(dn_lvl), .prev(dn_prev)
  );

  updn_step_decode u_decode (
    .up_lvl(up_lvl), .up_prev(up_prev),
    .dn_lvl(dn_lvl), .dn_prev(dn_prev),
    .step(step)
  );

  updn_count_reg #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n),
    .din(din), .step(step), .value(count)
  );

  updn_term_detect #(.WIDTH(WIDTH)) u_term (
    .value(count), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/updn_cascade_counter_chk.sv
module updn_cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_lvl,
  input logic             dn_lvl
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(din)));

  // R5
  carry_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count == TOP));

  // R6
  borrow_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count == '0));

  // R3 R4 R7
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n) |=> ((count == $past(count)) ||
                          (count == $past(count) + ONE) ||
                          (count == $past(count) - ONE)));

  // R9
  dual_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(up_lvl) && $rose(dn_lvl) && !clr && load_n) |=> $stable(count));
endmodule

bind updn_cascade_counter updn_cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din),
  .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
  .up_lvl(up_lvl), .dn_lvl(dn_lvl)
);

// File: tb/updn_cascade_counter_bench.sv
module updn_cascade_counter_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] din_lo = '0;
  logic [W-1:0] din_hi = '0;
  logic         up_in = 1'b1;
  logic         dn_in = 1'b1;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         carry_lo, borrow_lo, carry_hi, borrow_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  updn_cascade_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_updn_cascade_counter (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din_lo),
    .up_clk(up_in), .dn_clk(dn_in),
    .count(cnt_lo), .carry_n(carry_lo), .borrow_n(borrow_lo)
  );

  updn_cascade_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_hi (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din_hi),
    .up_clk(carry_lo), .dn_clk(borrow_lo),
    .count(cnt_hi), .carry_n(carry_hi), .borrow_n(borrow_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_in = 1'b0; settle();
    up_in = 1'b1; settle();
  endtask

  task automatic pulse_dn();
    dn_in = 1'b0; settle();
    dn_in = 1'b1; settle();
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 reset count", int'(cnt_lo), 0);
    chk("R5 idle carry", int'(carry_lo), 1);
    chk("R6 idle borrow", int'(borrow_lo), 1);
  endtask

  task automatic t_count_up();
    for (int i = 0; i < 3; i++) pulse_up();
    chk("R3 three up pulses", int'(cnt_lo), 3);
  endtask

  task automatic t_qualify();
    dn_in = 1'b0; settle();
    pulse_up();
    chk("R3 up blocked by low down strobe", int'(cnt_lo), 3);
    dn_in = 1'b1; settle();
    chk("R4 down edge with up high", int'(cnt_lo), 2);
  endtask

  task automatic t_down_wrap();
    pulse_dn(); pulse_dn();
    chk("R4 two down pulses", int'(cnt_lo), 0);
    chk("R6 borrow high while down high", int'(borrow_lo), 1);
    dn_in = 1'b0; settle();
    chk("R6 borrow low at zero", int'(borrow_lo), 0);
    dn_in = 1'b1; settle();
    chk("R7 wrap down to max", int'(cnt_lo), 15);
    chk("R6 borrow released", int'(borrow_lo), 1);
  endtask

  task automatic t_up_wrap();
    chk("R5 carry high while up high", int'(carry_lo), 1);
    up_in = 1'b0; settle();
    chk("R5 carry low at max", int'(carry_lo), 0);
    up_in = 1'b1; settle();
    chk("R7 wrap up to zero", int'(cnt_lo), 0);
    chk("R5 carry released", int'(carry_lo), 1);
  endtask

  task automatic t_load();
    din_lo = 4'd9; load_n = 1'b0; settle();
    chk("R2 load value", int'(cnt_lo), 9);
    pulse_up();
    chk("R8 up ignored during load", int'(cnt_lo), 9);
    load_n = 1'b1; settle();
    chk("R8 value kept after load", int'(cnt_lo), 9);
    pulse_up();
    chk("R8 resume after load", int'(cnt_lo), 10);
  endtask

  task automatic t_clear();
    clr = 1'b1; load_n = 1'b0; din_lo = 4'd5; settle();
    chk("R1 clear beats load", int'(cnt_lo), 0);
    pulse_dn();
    chk("R8 down ignored during clear", int'(cnt_lo), 0);
    clr = 1'b0; load_n = 1'b1; settle();
    chk("R1 zero after clear", int'(cnt_lo), 0);
    pulse_dn();
    chk("R8 resume after clear", int'(cnt_lo), 15);
  endtask

  task automatic t_dual_rise();
    up_in = 1'b0; dn_in = 1'b0; settle();
    chk("R9 falls do not count", int'(cnt_lo), 15);
    up_in = 1'b1; dn_in = 1'b1; settle();
    chk("R9 joint rise holds", int'(cnt_lo), 15);
  endtask

  task automatic t_cascade();
    din_lo = 4'd14; din_hi = 4'd2; load_n = 1'b0; settle();
    load_n = 1'b1; settle();
    chk("R10 cascade loaded", int'({cnt_hi, cnt_lo}), 8'h2E);
    pulse_up();
    chk("R10 cascade up low nibble", int'({cnt_hi, cnt_lo}), 8'h2F);
    pulse_up();
    chk("R10 cascade carry into high", int'({cnt_hi, cnt_lo}), 8'h30);
    pulse_dn();
    chk("R10 cascade borrow from high", int'({cnt_hi, cnt_lo}), 8'h2F);
    pulse_dn();
    chk("R10 cascade down low nibble", int'({cnt_hi, cnt_lo}), 8'h2E);
  endtask

  initial begin
    t_reset();
    t_count_up();
    t_qualify();
    t_down_wrap();
    t_up_wrap();
    t_load();
    t_clear();
    t_dual_rise();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule